// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block decides, in the same cycle as it sees them, how a five-stage in-order integer pipeline (Fetch, Decode, Execute, Memory, Writeback) avoids using stale register values. Branches in this pipeline are compared in Decode. The block receives register numbers and a few control flags from the pipeline registers. It returns four groups of controls: bypass selects for the two Execute operands, bypass enables for the two Decode branch-comparator inputs, hold enables for the Fetch and Decode registers, and a flush for the Execute register.

The block is purely combinational and keeps no state. The surrounding datapath applies its outputs at the next clock edge. When `flush_e` is set, the datapath must load the Execute pipeline register with a bubble in which every register-write and memory enable is cleared. Register number 0 is the hard-wired zero register and is never used as a bypass source.

The block has no state machine. Its outputs follow only from the current inputs.

Top module: `hz_unit`

## Requirements
- R1: `fwd_a_e` is 2'b10 (take the Memory-stage result) when `rs_e` is nonzero, `rs_e == wreg_m` and `regwr_m` is 1.
- R2: When R1 does not apply, `fwd_a_e` is 2'b01 (take the Writeback result) if `rs_e` is nonzero, `rs_e == wreg_w` and `regwr_w` is 1. In every other case it is 2'b00 (take the register file value).
- R3: A Memory-stage match wins over a Writeback-stage match. `fwd_b_e` follows R1 and R2 with `rt_e` in place of `rs_e`.
- R4: A source register number of 0 never produces a nonzero Execute select or a set Decode bypass bit.
- R5: A load-use stall is raised when `memrd_e` is 1 and either `rs_d` or `rt_d` equals `rt_e`.
- R6: `fwd_a_d` (or `fwd_b_d`) is 1 exactly when `rs_d` (or `rt_d`) is nonzero, equals `wreg_m`, and `regwr_m` is 1.
- R7: A branch stall is raised when `br_d` is 1, `regwr_e` is 1, and `wreg_e` equals `rs_d` or `rt_d`.
- R8: A branch stall is raised when `br_d` is 1, `memrd_m` is 1, and `wreg_m` equals `rs_d` or `rt_d`.
- R9: `stall_f`, `stall_d` and `flush_e` are all equal to the OR of the load-use stall and the branch stall.
- R10: While `br_d` is 0, the conditions of R7 and R8 raise no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_d | input | 5 | First source register number in Decode |
| rt_d | input | 5 | Second source register number in Decode |
| rs_e | input | 5 | First source register number in Execute |
| rt_e | input | 5 | Second source register number in Execute |
| wreg_e | input | 5 | Destination register number in Execute |
| wreg_m | input | 5 | Destination register number in Memory |
| wreg_w | input | 5 | Destination register number in Writeback |
| regwr_e | input | 1 | Execute instruction writes a register |
| regwr_m | input | 1 | Memory instruction writes a register |
| regwr_w | input | 1 | Writeback instruction writes a register |
| memrd_e | input | 1 | Execute instruction is a load |
| memrd_m | input | 1 | Memory instruction is a load |
| br_d | input | 1 | Decode instruction is a branch |
| fwd_a_e | output | 2 | Execute operand A select (00 register file, 01 Writeback, 10 Memory) |
| fwd_b_e | output | 2 | Execute operand B select (same encoding) |
| fwd_a_d | output | 1 | Bypass Memory result to the first branch-comparator input |
| fwd_b_d | output | 1 | Bypass Memory result to the second branch-comparator input |
| stall_f | output | 1 | Hold the Fetch register |
| stall_d | output | 1 | Hold the Decode register |
| flush_e | output | 1 | Load a bubble into the Execute register |

## Verification
The bench aims at cases where Memory and Writeback both hold the same destination. A design with the priority reversed would feed an older value to the ALU. It also covers destination 0 with the write flag set; a design without the zero guard would bypass a nonzero value in place of the hard-wired zero. Branches that depend on an ALU result one stage ahead, or on a load two stages ahead, are included; a design missing either term would compare stale operands. Non-branch instructions that meet the same register conditions are included too, and there a design that ignored `br_d` would stall for no reason. Random register numbers are drawn from a small range so that matches are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_W = 5;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_exec_fwd.sv
module hz_exec_fwd
    import hz_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] wreg_m,
    input  logic          regwr_m,
    input  logic [RW-1:0] wreg_w,
    input  logic          regwr_w,
    output fwd_sel_e      sel
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic src_live;
    logic hit_m;
    logic hit_w;

    always_comb begin
        src_live = (src != ZERO_REG);
        hit_m    = src_live && regwr_m && (src == wreg_m);
        hit_w    = src_live && regwr_w && (src == wreg_w);
        if (hit_m)      sel = FWD_MEM;
        else if (hit_w) sel = FWD_WB;
        else            sel = FWD_RF;

        // R4
        zero_src_chk: assert (src_live || sel == FWD_RF);
        // R1
        mem_wr_chk: assert (sel != FWD_MEM || regwr_m);
    end
endmodule

// File: rtl/hz_branch_fwd.sv
module hz_branch_fwd
    import hz_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] wreg_m,
    input  logic          regwr_m,
    output logic          byp
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    always_comb begin
        byp = (src != ZERO_REG) && regwr_m && (src == wreg_m);
        // R6
        dec_byp_wr_chk: assert (!byp || regwr_m);
    end
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
    import hz_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] rs_d,
    input  logic [RW-1:0] rt_d,
    input  logic [RW-1:0] rt_e,
    input  logic [RW-1:0] wreg_e,
    input  logic [RW-1:0] wreg_m,
    input  logic          regwr_e,
    input  logic          memrd_e,
    input  logic          memrd_m,
    input  logic          br_d,
    output logic          hold
);
    logic load_use;
    logic br_on_alu;
    logic br_on_load;

    always_comb begin
        load_use   = memrd_e && ((rs_d == rt_e) || (rt_d == rt_e));
        br_on_alu  = br_d && regwr_e && ((wreg_e == rs_d) || (wreg_e == rt_d));
        br_on_load = br_d && memrd_m && ((wreg_m == rs_d) || (wreg_m == rt_d));
        hold       = load_use || br_on_alu || br_on_load;

        // R10
        stall_cause_chk: assert (!hold || br_d || memrd_e);
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] rs_d,
    input  logic [RW-1:0] rt_d,
    input  logic [RW-1:0] rs_e,
    input  logic [RW-1:0] rt_e,
    input  logic [RW-1:0] wreg_e,
    input  logic [RW-1:0] wreg_m,
    input  logic [RW-1:0] wreg_w,
    input  logic          regwr_e,
    input  logic          regwr_m,
    input  logic          regwr_w,
    input  logic          memrd_e,
    input  logic          memrd_m,
    input  logic          br_d,
    output logic [1:0]    fwd_a_e,
    output logic [1:0]    fwd_b_e,
    output logic          fwd_a_d,
    output logic          fwd_b_d,
    output logic          stall_f,
    output logic          stall_d,
    output logic          flush_e
);
    localparam int N_SRC = 2;

    logic [RW-1:0] src_e [N_SRC];
    logic [RW-1:0] src_d [N_SRC];
    fwd_sel_e      sel_e [N_SRC];
    logic          byp_d [N_SRC];
    logic          hold;

    assign src_e[0] = rs_e;
    assign src_e[1] = rt_e;
    assign src_d[0] = rs_d;
    assign src_d[1] = rt_d;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        hz_exec_fwd #(.RW(RW)) u_exec_fwd (
            .src     (src_e[g]),
            .wreg_m  (wreg_m),
            .regwr_m (regwr_m),
            .wreg_w  (wreg_w),
            .regwr_w (regwr_w),
            .sel     (sel_e[g])
        );
        hz_branch_fwd #(.RW(RW)) u_branch_fwd (
            .src     (src_d[g]),
            .wreg_m  (wreg_m),
            .regwr_m (regwr_m),
            .byp     (byp_d[g])
        );
    end

    hz_stall_detect #(.RW(RW)) u_stall (
        .rs_d    (rs_d),
        .rt_d    (rt_d),
        .rt_e    (rt_e),
        .wreg_e  (wreg_e),
        .wreg_m  (wreg_m),
        .regwr_e (regwr_e),
        .memrd_e (memrd_e),
        .memrd_m (memrd_m),
        .br_d    (br_d),
        .hold    (hold)
    );

    always_comb begin
        fwd_a_e = sel_e[0];
        fwd_b_e = sel_e[1];
        fwd_a_d = byp_d[0];
        fwd_b_d = byp_d[1];
        stall_f = hold;
        stall_d = hold;
        flush_e = hold;

        // R9
        flush_cause_chk: assert (!flush_e || br_d || memrd_e);
    end
endmodule

// File: tb/hz_unit_bench.sv
module hz_unit_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0] rs_d, rt_d, rs_e, rt_e, wreg_e, wreg_m, wreg_w;
    logic regwr_e, regwr_m, regwr_w, memrd_e, memrd_m, br_d;
    logic [1:0] fwd_a_e, fwd_b_e;
    logic fwd_a_d, fwd_b_d, stall_f, stall_d, flush_e;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    hz_unit u_hz_unit (
        .rs_d(rs_d), .rt_d(rt_d), .rs_e(rs_e), .rt_e(rt_e),
        .wreg_e(wreg_e), .wreg_m(wreg_m), .wreg_w(wreg_w),
        .regwr_e(regwr_e), .regwr_m(regwr_m), .regwr_w(regwr_w),
        .memrd_e(memrd_e), .memrd_m(memrd_m), .br_d(br_d),
        .fwd_a_e(fwd_a_e), .fwd_b_e(fwd_b_e),
        .fwd_a_d(fwd_a_d), .fwd_b_d(fwd_b_d),
        .stall_f(stall_f), .stall_d(stall_d), .flush_e(flush_e)
    );

    function automatic logic [1:0] exp_sel(logic [4:0] s);
        if (s != 0 && regwr_m && s == wreg_m) return 2'b10;
        if (s != 0 && regwr_w && s == wreg_w) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_byp(logic [4:0] s);
        return (s != 0) && regwr_m && (s == wreg_m);
    endfunction

    function automatic logic exp_hold();
        logic lu, ba, bl;
        lu = memrd_e && (rs_d == rt_e || rt_d == rt_e);
        ba = br_d && regwr_e && (wreg_e == rs_d || wreg_e == rt_d);
        bl = br_d && memrd_m && (wreg_m == rs_d || wreg_m == rt_d);
        return lu || ba || bl;
    endfunction

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic h;
        h = exp_hold();
        chk({tag, " R1/R2/R3 fwd_a_e"}, fwd_a_e, exp_sel(rs_e));
        chk({tag, " R3 fwd_b_e"}, fwd_b_e, exp_sel(rt_e));
        chk({tag, " R6 fwd_a_d"}, {1'b0, fwd_a_d}, {1'b0, exp_byp(rs_d)});
        chk({tag, " R6 fwd_b_d"}, {1'b0, fwd_b_d}, {1'b0, exp_byp(rt_d)});
        chk({tag, " R9 stall_f"}, {1'b0, stall_f}, {1'b0, h});
        chk({tag, " R9 stall_d"}, {1'b0, stall_d}, {1'b0, h});
        chk({tag, " R9 flush_e"}, {1'b0, flush_e}, {1'b0, h});
    endtask

    task automatic clear_in();
        {rs_d, rt_d, rs_e, rt_e, wreg_e, wreg_m, wreg_w} = '0;
        {regwr_e, regwr_m, regwr_w, memrd_e, memrd_m, br_d} = '0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 100000) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        clear_in();
        settle();
        // reset/idle state: everything from the register file, no stall
        chk("idle R2 fwd_a_e", fwd_a_e, 2'b00);
        chk("idle R9 flush_e", {1'b0, flush_e}, 2'b00);

        // R1: Memory-stage bypass
        @(posedge clk); clear_in(); rs_e = 5'd3; wreg_m = 5'd3; regwr_m = 1; settle();
        chk("R1 mem fwd", fwd_a_e, 2'b10);
        // R2: Writeback bypass
        @(posedge clk); clear_in(); rs_e = 5'd4; wreg_w = 5'd4; regwr_w = 1; settle();
        chk("R2 wb fwd", fwd_a_e, 2'b01);
        // R2: match with write flag clear gives register file
        @(posedge clk); clear_in(); rs_e = 5'd4; wreg_w = 5'd4; settle();
        chk("R2 no write", fwd_a_e, 2'b00);
        // R3: both stages match, Memory wins; operand B
        @(posedge clk); clear_in(); rt_e = 5'd7; wreg_m = 5'd7; wreg_w = 5'd7;
        regwr_m = 1; regwr_w = 1; settle();
        chk("R3 priority B", fwd_b_e, 2'b10);
        chk("R3 A untouched", fwd_a_e, 2'b00);
        // R4: register 0 never bypassed
        @(posedge clk); clear_in(); regwr_m = 1; regwr_w = 1; settle();
        chk("R4 zero A", fwd_a_e, 2'b00);
        chk("R4 zero B", fwd_b_e, 2'b00);
        chk("R4 zero dec", {fwd_a_d, fwd_b_d}, 2'b00);
        // R5: load-use stall on rt_d
        @(posedge clk); clear_in(); rt_d = 5'd9; rt_e = 5'd9; rs_d = 5'd1; memrd_e = 1; settle();
        chk("R5 load-use", {stall_f, flush_e}, 2'b11);
        // R5: same registers, not a load
        @(posedge clk); memrd_e = 0; settle();
        chk("R5 no load", {stall_f, flush_e}, 2'b00);
        // R6: Decode bypass on rt_d
        @(posedge clk); clear_in(); rt_d = 5'd12; wreg_m = 5'd12; regwr_m = 1; settle();
        chk("R6 dec byp", {fwd_a_d, fwd_b_d}, 2'b01);
        // R7: branch on ALU result in Execute
        @(posedge clk); clear_in(); br_d = 1; rs_d = 5'd6; wreg_e = 5'd6; regwr_e = 1; settle();
        chk("R7 br alu", {stall_d, flush_e}, 2'b11);
        // R10: same without a branch
        @(posedge clk); br_d = 0; settle();
        chk("R10 no br alu", {stall_d, flush_e}, 2'b00);
        // R8: branch on a load in Memory
        @(posedge clk); clear_in(); br_d = 1; rt_d = 5'd8; wreg_m = 5'd8; memrd_m = 1; settle();
        chk("R8 br load", {stall_f, stall_d}, 2'b11);
        // R10: load in Memory, no branch
        @(posedge clk); br_d = 0; settle();
        chk("R10 no br load", {stall_f, stall_d}, 2'b00);

        // constrained random: small register range to force matches
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            rs_d = 5'($urandom_range(0, 3)); rt_d = 5'($urandom_range(0, 3));
            rs_e = 5'($urandom_range(0, 3)); rt_e = 5'($urandom_range(0, 3));
            wreg_e = 5'($urandom_range(0, 3)); wreg_m = 5'($urandom_range(0, 3));
            wreg_w = 5'($urandom_range(0, 3));
            regwr_e = 1'($urandom); regwr_m = 1'($urandom); regwr_w = 1'($urandom);
            memrd_e = 1'($urandom); memrd_m = 1'($urandom); br_d = 1'($urandom);
            settle();
            check_all("rand R4 R5 R7 R8 R10");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule